// File: doc/BRIEF.md
# Three-Input Multiply-Accumulate Slice

This block is one arithmetic slice of a signal-processing datapath. A signed multiplier forms the product of two 18-bit operands. A 48-bit adder/subtractor then combines three operands chosen by an operating-mode word: X, Y and Z. It computes Z plus or minus (X + Y + carry-in) and holds the result in an output register. That register can be fed back into the X or Z multiplexer, so one slice can accumulate products, add a wide constant from the C port, or take a partial sum from a neighbouring slice through its cascade input.

The product is sign-extended to 48 bits and split into two halves. X carries the low half and Y carries the high half, so X + Y rebuilds the full product inside the three-operand sum. Two static configuration inputs add an optional register stage ahead of the multiplier and an optional register stage after it. All operands and control bits travel through the same stages, and an output-valid flag follows the configured latency. The output register is the accumulator, and a synchronous reset clears it. The registered result is also driven on a cascade output for the next slice.

Top module: `mac3_slice`

## Requirements
- R1: A synchronous reset, `rst` high at a rising edge, clears `p`, `cascadeOut`, `pValid` and every internal pipeline stage to zero.
- R2: A sample taken with `inValid` high produces `pValid` high exactly 1 + `cfgInReg` + `cfgMulReg` rising edges later, and samples leave in the order they arrived.
- R3: With `opMode` = 7'h05 (X = product low half, Y = product high half, Z = zero), `carryIn` = 0 and `subtract` = 0, `p` equals the two's-complement product of `a` and `b`, sign-extended to 48 bits.
- R4: The product halves are defined as follows. X code 01 gives bits 23:0 of the sign-extended product, zero-extended. Y code 01 gives bits 47:24 of that product, with bits 23:0 zero.
- R5: X is chosen by `opMode[1:0]`: 00 zero, 01 product low half, 10 accumulator, 11 the concatenation {a, b} zero-extended. Y is chosen by `opMode[3:2]`: 00 zero, 01 product high half, 10 C port, 11 all ones. Z is chosen by `opMode[6:4]`: 000 zero, 001 accumulator, 010 C port, 011 `cascadeIn`.
- R6: With `subtract` = 0, `p` = Z + X + Y + `carryIn`, taken modulo 2^48.
- R7: With `subtract` = 1, `p` = Z − (X + Y + `carryIn`), taken modulo 2^48.
- R8: When the accumulator is selected on X or on Z, the value used is the `p` produced by the previous valid sample, so consecutive valid samples accumulate.
- R9: A cycle with `inValid` low leaves `p` unchanged, whatever the other inputs carry.
- R10: `cascadeOut` always equals `p`.
- R11: Z codes 100 to 111 select zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfgInReg | input | 1 | Static: enables the register stage ahead of the multiplier |
| cfgMulReg | input | 1 | Static: enables the register stage after the multiplier |
| inValid | input | 1 | Marks a sample to be processed |
| opMode | input | 7 | Operand select: [1:0] X, [3:2] Y, [6:4] Z |
| subtract | input | 1 | 1: Z − (X+Y+Cin); 0: Z + (X+Y+Cin) |
| carryIn | input | 1 | Carry into the X+Y sum |
| a | input | 18 | Signed multiplier operand, upper part of the concatenation |
| b | input | 18 | Signed multiplier operand, lower part of the concatenation |
| c | input | 48 | Wide operand port |
| cascadeIn | input | 48 | Partial sum from the neighbouring slice |
| p | output | 48 | Accumulator / result |
| pValid | output | 1 | Result valid strobe |
| cascadeOut | output | 48 | Copy of the result for the next slice |

## Verification
The bench builds the slice with its default widths: 18-bit multiplier operands and a 48-bit result, split into two 24-bit product halves. This brings the extreme signed products, such as −2^17 × −2^17, and the borrow across the full 48 bits into reach. The bench runs the same stimulus under all four settings of the two register-stage inputs, resetting between them. Each setting has its own latency, and the carried controls must stay aligned with their operands. Accumulation runs both with idle gaps between samples and back to back.

// File: rtl/mac3_pkg.sv
package mac3_pkg;

  localparam int OPM_W = 7;

  typedef enum logic [1:0] {
    X_ZERO    = 2'b00,
    X_PROD_LO = 2'b01,
    X_ACC     = 2'b10,
    X_CONCAT  = 2'b11
  } xSel_e;

  typedef enum logic [1:0] {
    Y_ZERO    = 2'b00,
    Y_PROD_HI = 2'b01,
    Y_CPORT   = 2'b10,
    Y_ONES    = 2'b11
  } ySel_e;

  typedef enum logic [2:0] {
    Z_ZERO    = 3'b000,
    Z_ACC     = 3'b001,
    Z_CPORT   = 3'b010,
    Z_CASCADE = 3'b011
  } zSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadIn;
    logic loadMul;
    logic loadAcc;
  } strobes_t;

endpackage

// File: rtl/mac3_cla.sv
// Group carry-lookahead adder: bit carries inside a group, group carry
// formed from group generate/propagate.
module mac3_cla #(
  parameter int W   = 48,
  parameter int GRP = 4
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         cIn,
  output logic [W-1:0] sum
);
  localparam int NGRP = W / GRP;

  logic [W-1:0] gen;
  logic [W-1:0] prp;

  assign gen = opA & opB;
  assign prp = opA ^ opB;

  always_comb begin
    logic grpIn;
    logic cy;
    logic gg;
    logic pg;
    int   idx;
    sum   = '0;
    grpIn = cIn;
    for (int gi = 0; gi < NGRP; gi++) begin
      cy = grpIn;
      gg = 1'b0;
      pg = 1'b1;
      for (int j = 0; j < GRP; j++) begin
        idx      = gi * GRP + j;
        sum[idx] = prp[idx] ^ cy;
        cy       = gen[idx] | (prp[idx] & cy);
        gg       = gen[idx] | (prp[idx] & gg);
        pg       = pg & prp[idx];
      end
      grpIn = gg | (pg & grpIn);
    end
  end
endmodule

// File: rtl/mac3_addsub.sv
// Two chained lookahead stages: X+Y+Cin first, then Z +/- that sum.
module mac3_addsub #(
  parameter int W = 48
) (
  input  logic [W-1:0] xOp,
  input  logic [W-1:0] yOp,
  input  logic [W-1:0] zOp,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] result
);
  logic [W-1:0] partSum;
  logic [W-1:0] addend;

  mac3_cla #(.W(W)) u_stage1 (
    .opA(xOp), .opB(yOp), .cIn(cin), .sum(partSum)
  );

  // subtract: invert the partial sum and add one through the carry
  assign addend = partSum ^ {W{sub}};

  mac3_cla #(.W(W)) u_stage2 (
    .opA(zOp), .opB(addend), .cIn(sub), .sum(result)
  );
endmodule

// File: rtl/mac3_mul.sv
// Signed multiplier; product sign-extended and split into two halves.
module mac3_mul #(
  parameter int A_W = 18,
  parameter int B_W = 18,
  parameter int P_W = 48
) (
  input  logic [A_W-1:0] opA,
  input  logic [B_W-1:0] opB,
  output logic [P_W-1:0] partLo,
  output logic [P_W-1:0] partHi
);
  localparam int PROD_W = A_W + B_W;
  localparam int SPLIT  = P_W / 2;

  logic signed [PROD_W-1:0] prod;
  logic        [P_W-1:0]    prodExt;

  assign prod    = $signed(opA) * $signed(opB);
  assign prodExt = {{(P_W-PROD_W){prod[PROD_W-1]}}, prod};
  assign partLo  = {{(P_W-SPLIT){1'b0}}, prodExt[SPLIT-1:0]};
  assign partHi  = {prodExt[P_W-1:SPLIT], {SPLIT{1'b0}}};
endmodule

// File: rtl/mac3_ctrl.sv
// Valid tracking through the optional stages; issues load strobes.
module mac3_ctrl
  import mac3_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     cfgInReg,
  input  logic     cfgMulReg,
  input  logic     inValid,
  output strobes_t st,
  output logic     pValid
);
  logic inValidQ;
  logic mulValidQ;
  logic s1Valid;
  logic s2Valid;

  assign s1Valid = cfgInReg  ? inValidQ  : inValid;
  assign s2Valid = cfgMulReg ? mulValidQ : s1Valid;

  assign st.loadIn  = inValid;
  assign st.loadMul = s1Valid;
  assign st.loadAcc = s2Valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      inValidQ  <= 1'b0;
      mulValidQ <= 1'b0;
      pValid    <= 1'b0;
    end else begin
      inValidQ  <= inValid;
      mulValidQ <= s1Valid;
      pValid    <= s2Valid;
    end
  end
endmodule

// File: rtl/mac3_datapath.sv
// Operand stages, multiplier, X/Y/Z selection and the accumulator.
module mac3_datapath
  import mac3_pkg::*;
#(
  parameter int A_W = 18,
  parameter int B_W = 18,
  parameter int P_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfgInReg,
  input  logic             cfgMulReg,
  input  strobes_t         st,
  input  logic [OPM_W-1:0] opMode,
  input  logic             subtract,
  input  logic             carryIn,
  input  logic [A_W-1:0]   a,
  input  logic [B_W-1:0]   b,
  input  logic [P_W-1:0]   c,
  input  logic [P_W-1:0]   cascadeIn,
  output logic [P_W-1:0]   accOut
);
  localparam int CAT_W = A_W + B_W;

  // stage 1: operands ahead of the multiplier
  logic [A_W-1:0]   aQ,    aS1;
  logic [B_W-1:0]   bQ,    bS1;
  logic [P_W-1:0]   cQ,    cS1;
  logic [P_W-1:0]   casQ,  casS1;
  logic [OPM_W-1:0] opmQ,  opmS1;
  logic             subQ,  subS1;
  logic             cinQ,  cinS1;

  always_ff @(posedge clk) begin
    if (rst) begin
      aQ <= '0; bQ <= '0; cQ <= '0; casQ <= '0;
      opmQ <= '0; subQ <= 1'b0; cinQ <= 1'b0;
    end else if (st.loadIn) begin
      aQ <= a; bQ <= b; cQ <= c; casQ <= cascadeIn;
      opmQ <= opMode; subQ <= subtract; cinQ <= carryIn;
    end
  end

  assign aS1   = cfgInReg ? aQ   : a;
  assign bS1   = cfgInReg ? bQ   : b;
  assign cS1   = cfgInReg ? cQ   : c;
  assign casS1 = cfgInReg ? casQ : cascadeIn;
  assign opmS1 = cfgInReg ? opmQ : opMode;
  assign subS1 = cfgInReg ? subQ : subtract;
  assign cinS1 = cfgInReg ? cinQ : carryIn;

  logic [P_W-1:0] loS1, hiS1, catS1;

  mac3_mul #(.A_W(A_W), .B_W(B_W), .P_W(P_W)) u_mul (
    .opA(aS1), .opB(bS1), .partLo(loS1), .partHi(hiS1)
  );

  assign catS1 = {{(P_W-CAT_W){1'b0}}, aS1, bS1};

  // stage 2: after the multiplier
  logic [P_W-1:0]   loQ,   loS2;
  logic [P_W-1:0]   hiQ,   hiS2;
  logic [P_W-1:0]   catQ,  catS2;
  logic [P_W-1:0]   c2Q,   cS2;
  logic [P_W-1:0]   cas2Q, casS2;
  logic [OPM_W-1:0] opm2Q, opmS2;
  logic             sub2Q, subS2;
  logic             cin2Q, cinS2;

  always_ff @(posedge clk) begin
    if (rst) begin
      loQ <= '0; hiQ <= '0; catQ <= '0; c2Q <= '0; cas2Q <= '0;
      opm2Q <= '0; sub2Q <= 1'b0; cin2Q <= 1'b0;
    end else if (st.loadMul) begin
      loQ <= loS1; hiQ <= hiS1; catQ <= catS1; c2Q <= cS1; cas2Q <= casS1;
      opm2Q <= opmS1; sub2Q <= subS1; cin2Q <= cinS1;
    end
  end

  assign loS2  = cfgMulReg ? loQ   : loS1;
  assign hiS2  = cfgMulReg ? hiQ   : hiS1;
  assign catS2 = cfgMulReg ? catQ  : catS1;
  assign cS2   = cfgMulReg ? c2Q   : cS1;
  assign casS2 = cfgMulReg ? cas2Q : casS1;
  assign opmS2 = cfgMulReg ? opm2Q : opmS1;
  assign subS2 = cfgMulReg ? sub2Q : subS1;
  assign cinS2 = cfgMulReg ? cin2Q : cinS1;

  // stage 3: operand selection and the accumulator
  logic [P_W-1:0] accQ;
  logic [P_W-1:0] xOp, yOp, zOp, sumOut;
  xSel_e xSel;
  ySel_e ySel;
  zSel_e zSel;

  assign xSel = xSel_e'(opmS2[1:0]);
  assign ySel = ySel_e'(opmS2[3:2]);
  assign zSel = zSel_e'(opmS2[6:4]);

  always_comb begin
    unique case (xSel)
      X_PROD_LO: xOp = loS2;
      X_ACC:     xOp = accQ;
      X_CONCAT:  xOp = catS2;
      default:   xOp = '0;
    endcase
  end

  always_comb begin
    unique case (ySel)
      Y_PROD_HI: yOp = hiS2;
      Y_CPORT:   yOp = cS2;
      Y_ONES:    yOp = '1;
      default:   yOp = '0;
    endcase
  end

  always_comb begin
    case (zSel)
      Z_ACC:     zOp = accQ;
      Z_CPORT:   zOp = cS2;
      Z_CASCADE: zOp = casS2;
      default:   zOp = '0;
    endcase
  end

  mac3_addsub #(.W(P_W)) u_addsub (
    .xOp(xOp), .yOp(yOp), .zOp(zOp), .cin(cinS2), .sub(subS2), .result(sumOut)
  );

  always_ff @(posedge clk) begin
    if (rst)             accQ <= '0;
    else if (st.loadAcc) accQ <= sumOut;
  end

  assign accOut = accQ;
endmodule

// File: rtl/mac3_slice.sv
module mac3_slice
  import mac3_pkg::*;
#(
  parameter int A_W = 18,
  parameter int B_W = 18,
  parameter int P_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfgInReg,
  input  logic             cfgMulReg,
  input  logic             inValid,
  input  logic [OPM_W-1:0] opMode,
  input  logic             subtract,
  input  logic             carryIn,
  input  logic [A_W-1:0]   a,
  input  logic [B_W-1:0]   b,
  input  logic [P_W-1:0]   c,
  input  logic [P_W-1:0]   cascadeIn,
  output logic [P_W-1:0]   p,
  output logic             pValid,
  output logic [P_W-1:0]   cascadeOut
);
  strobes_t       st;
  logic [P_W-1:0] accOut;

  mac3_ctrl u_ctrl (
    .clk(clk), .rst(rst), .cfgInReg(cfgInReg), .cfgMulReg(cfgMulReg),
    .inValid(inValid), .st(st), .pValid(pValid)
  );

  mac3_datapath #(.A_W(A_W), .B_W(B_W), .P_W(P_W)) u_dp (
    .clk(clk), .rst(rst), .cfgInReg(cfgInReg), .cfgMulReg(cfgMulReg),
    .st(st), .opMode(opMode), .subtract(subtract), .carryIn(carryIn),
    .a(a), .b(b), .c(c), .cascadeIn(cascadeIn), .accOut(accOut)
  );

  assign p          = accOut;
  assign cascadeOut = accOut;
endmodule

// File: rtl/mac3_slice_chk.sv
module mac3_slice_chk #(
  parameter int P_W = 48
) (
  input logic           clk,
  input logic           rst,
  input logic           cfgInReg,
  input logic           cfgMulReg,
  input logic           inValid,
  input logic [6:0]     opMode,
  input logic           subtract,
  input logic           carryIn,
  input logic [P_W-1:0] p,
  input logic           pValid
);
  logic [1:0] sinceRst;

  always_ff @(posedge clk) begin
    if (rst)                 sinceRst <= 2'd0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (p == '0 && !pValid)); // R1

  AST_LAT_BYPASS: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 2'd1 && !cfgInReg && !cfgMulReg) |-> pValid == $past(inValid)); // R2

  AST_LAT_ONE_STAGE: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 2'd2 && (cfgInReg ^ cfgMulReg)) |-> pValid == $past(inValid, 2)); // R2

  AST_LAT_TWO_STAGE: assert property (@(posedge clk) disable iff (rst)
    (sinceRst == 2'd3 && cfgInReg && cfgMulReg) |-> pValid == $past(inValid, 3)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 2'd1 && !pValid) |-> $stable(p)); // R9

  AST_ACC_STEP: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 2'd1 && !cfgInReg && !cfgMulReg && $past(inValid) &&
     $past(opMode) == 7'h10 && !$past(subtract) && $past(carryIn))
    |-> p == $past(p) + 1'b1); // R8
endmodule

bind mac3_slice mac3_slice_chk #(.P_W(P_W)) u_chk (
  .clk(clk), .rst(rst), .cfgInReg(cfgInReg), .cfgMulReg(cfgMulReg),
  .inValid(inValid), .opMode(opMode), .subtract(subtract),
  .carryIn(carryIn), .p(p), .pValid(pValid)
);

// File: tb/mac3_slice_bench.sv
module mac3_slice_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 48;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfgInReg = 1'b0;
  logic        cfgMulReg = 1'b0;
  logic        inValid = 1'b0;
  logic [6:0]  opMode = '0;
  logic        subtract = 1'b0;
  logic        carryIn = 1'b0;
  logic [17:0] a = '0;
  logic [17:0] b = '0;
  logic [PW-1:0] c = '0;
  logic [PW-1:0] cascadeIn = '0;
  logic [PW-1:0] p;
  logic          pValid;
  logic [PW-1:0] cascadeOut;

  mac3_slice u_mac3_slice (
    .clk(clk), .rst(rst), .cfgInReg(cfgInReg), .cfgMulReg(cfgMulReg),
    .inValid(inValid), .opMode(opMode), .subtract(subtract), .carryIn(carryIn),
    .a(a), .b(b), .c(c), .cascadeIn(cascadeIn),
    .p(p), .pValid(pValid), .cascadeOut(cascadeOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [PW-1:0] expQ[$];
  int            cycQ[$];
  string         tagQ[$];
  logic [PW-1:0] model = '0;
  logic [PW-1:0] lastP = '0;

  task automatic chk(input bit ok, input string req, input logic [PW-1:0] act,
                     input logic [PW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // independent reference of the requirements R3..R8, R11
  function automatic logic [PW-1:0] calc(input logic [6:0] opm,
      input logic [17:0] av, input logic [17:0] bv, input logic [PW-1:0] cv,
      input logic cinv, input logic subv, input logic [PW-1:0] casv,
      input logic [PW-1:0] acc);
    logic signed [35:0] pr;
    logic [PW-1:0] ext, lo, hi, x, y, z, s;
    pr  = $signed(av) * $signed(bv);
    ext = {{12{pr[35]}}, pr};
    lo  = {24'b0, ext[23:0]};
    hi  = {ext[47:24], 24'b0};
    case (opm[1:0])
      2'b01: x = lo;
      2'b10: x = acc;
      2'b11: x = {12'b0, av, bv};
      default: x = '0;
    endcase
    case (opm[3:2])
      2'b01: y = hi;
      2'b10: y = cv;
      2'b11: y = '1;
      default: y = '0;
    endcase
    case (opm[6:4])
      3'b001: z = acc;
      3'b010: z = cv;
      3'b011: z = casv;
      default: z = '0;
    endcase
    s = x + y + {47'b0, cinv};
    return subv ? z - s : z + s;
  endfunction

  task automatic issue(input string tag, input logic [6:0] opm,
      input logic [17:0] av, input logic [17:0] bv, input logic [PW-1:0] cv,
      input logic cinv, input logic subv, input logic [PW-1:0] casv);
    @(negedge clk);
    inValid = 1'b1; opMode = opm; a = av; b = bv; c = cv;
    carryIn = cinv; subtract = subv; cascadeIn = casv;
    model = calc(opm, av, bv, cv, cinv, subv, casv, model);
    expQ.push_back(model);
    cycQ.push_back(cyc);
    tagQ.push_back(tag);
  endtask

  // idle cycle with accumulate-looking junk on the inputs (R9)
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0; opMode = 7'h12; carryIn = 1'b1; subtract = 1'b0;
      a = 18'h1FFFF; b = 18'h3; c = 48'hFFFF_0000_1234; cascadeIn = 48'h77;
    end
  endtask

  // monitor: pops expected results as the slice produces them
  always @(negedge clk) begin
    if (!rst) begin
      if (pValid) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R2 unexpected pValid", p, '0);
        end else begin
          logic [PW-1:0] e;
          int ic;
          string t;
          e  = expQ.pop_front();
          ic = cycQ.pop_front();
          t  = tagQ.pop_front();
          chk(p == e, t, p, e);
          chk(cyc - ic == 1 + int'(cfgInReg) + int'(cfgMulReg), "R2 latency",
              PW'(cyc - ic), PW'(1 + int'(cfgInReg) + int'(cfgMulReg)));
          chk(cascadeOut == p, "R10 cascadeOut", cascadeOut, p);
          lastP = p;
        end
      end else begin
        chk(p == lastP, "R9 idle hold", p, lastP);
      end
    end
  end

  task automatic resetDut(input logic inCfg, input logic mulCfg);
    @(negedge clk);
    rst = 1'b1; inValid = 1'b0;
    cfgInReg = inCfg; cfgMulReg = mulCfg;
    repeat (2) @(negedge clk);
    chk(p == '0, "R1 reset p", p, '0);
    chk(cascadeOut == '0, "R1 reset cascadeOut", cascadeOut, '0);
    chk(PW'(pValid) == '0, "R1 reset pValid", PW'(pValid), '0);
    expQ.delete(); cycQ.delete(); tagQ.delete();
    model = '0; lastP = '0;
    rst = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired", '0, '0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int cfg = 0; cfg < 4; cfg++) begin
      resetDut(cfg[1], cfg[0]);
      // R3 signed products
      issue("R3 min*min", 7'h05, 18'h20000, 18'h20000, '0, 1'b0, 1'b0, '0);
      issue("R3 max*min", 7'h05, 18'h1FFFF, 18'h20000, '0, 1'b0, 1'b0, '0);
      issue("R3 mixed",   7'h05, 18'd12345, -18'sd678, '0, 1'b0, 1'b0, '0);
      // R4 product halves alone
      issue("R4 low half",  7'h01, -18'sd3, 18'd5, '0, 1'b0, 1'b0, '0);
      issue("R4 high half", 7'h04, -18'sd3, 18'd5, '0, 1'b0, 1'b0, '0);
      // R5 selections
      issue("R5 X concat", 7'h03, 18'h2AAAA, 18'h15555, '0, 1'b0, 1'b0, '0);
      issue("R5 Y cport",  7'h08, '0, '0, 48'h1234_5678_9ABC, 1'b0, 1'b0, '0);
      issue("R5 Y ones",   7'h0C, '0, '0, '0, 1'b0, 1'b0, '0);
      issue("R5 Z cascade", 7'h30, '0, '0, '0, 1'b0, 1'b0, 48'hA5A5_0000_5A5A);
      idle(2);
      // R6 add
      issue("R6 add concat ones cin", 7'h2F, 18'h00F0F, 18'h3C3C3, 48'h0000_FFFF_FFFF,
            1'b1, 1'b0, '0);
      issue("R6 add C plus product", 7'h25, -18'sd1000, 18'd999, 48'd5000, 1'b0, 1'b0, '0);
      // R7 subtract
      issue("R7 C minus product", 7'h25, -18'sd1000, 18'd999, 48'd5000, 1'b0, 1'b1, '0);
      issue("R7 borrow full width", 7'h2F, 18'h0, 18'h1, 48'h0, 1'b0, 1'b1, '0);
      idle(3);
      // R8 accumulate with gaps, R9 idle between
      issue("R8 seed from C", 7'h08, '0, '0, 48'd100, 1'b0, 1'b0, '0);
      issue("R8 acc product", 7'h15, 18'd3, 18'd7, '0, 1'b0, 1'b0, '0);
      idle(2);
      issue("R8 acc product gap", 7'h15, 18'd3, 18'd7, '0, 1'b0, 1'b0, '0);
      idle(1);
      issue("R8 X and Z accumulator", 7'h12, '0, '0, '0, 1'b0, 1'b0, '0);
      issue("R8 acc subtract", 7'h15, -18'sd4, 18'd50, '0, 1'b1, 1'b1, '0);
      // R11 reserved Z codes
      issue("R11 Z 101", 7'h58, '0, '0, 48'd5, 1'b0, 1'b0, 48'd9);
      issue("R11 Z 111", 7'h70, '0, '0, 48'd5, 1'b1, 1'b0, 48'd9);
      // R8 back-to-back increments
      for (int k = 0; k < 4; k++)
        issue("R8 back-to-back", 7'h10, '0, '0, '0, 1'b1, 1'b0, '0);
      idle(6);
      chk(PW'(expQ.size()) == '0, "R2 drained", PW'(expQ.size()), '0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule